// File: doc/BRIEF.md
# Reset and NMI Control Unit

This unit decides when a small microcontroller is held in reset and tells the outside world about it. Three things can start a reset. The first is the external active-low reset pin, which passes through a synchronizer and a spike filter. The second is a software request, and the third is a watchdog timeout. Each reset drives an internal reset for a fixed number of clock cycles; a hardware reset instead holds it for as long as the filtered pin stays low. A separate active-low indication output stays low after the internal reset ends. It is released only when software issues an end-of-initialization command.

When software has set the bidirectional enable, the unit pulls the reset pin low through an open-drain enable for the whole internal reset, whatever started it. The pin low that the unit causes itself is masked from the filter, so it cannot start a second reset. The cause of the last reset is kept for software to read.

The unit also watches the non-maskable interrupt pin. After a two-flop synchronizer, each high-to-low transition gives a one-cycle trap request. A power-down request is accepted only while the synchronized interrupt pin is low. Power-down status then stays set until a filtered hardware reset.

Top module: `rst_nmi_ctrl`

## Requirements
- R1: A low pulse on `rst_pin_n` that lasts fewer than PASS_CYC (default 6) clock cycles starts no reset. This includes pulses of REJECT_CYC (default 3) cycles or less.
- R2: Holding `rst_pin_n` low for at least PASS_CYC cycles raises `sys_rst` and sets `rst_cause` to 1 (hardware). `sys_rst` stays high while the filtered pin is low, and for SEQ_CYC cycles after it is released.
- R3: A `sw_rst_req` or `wdt_timeout` pulse while idle makes `sys_rst` high for exactly SEQ_CYC (default 16) cycles. `rst_cause` records 2 for software or 3 for watchdog. A watchdog request beats a software request in the same cycle, and a filtered hardware reset beats both.
- R4: After the block's power-on reset, and during and after any reset, `rst_ind_n` is 0. It returns to 1 only on an `einit_cmd` given while `sys_rst` is 0. An `einit_cmd` given during the reset has no effect.
- R5: `rst_pin_pd` is 1 in exactly the cycles in which `sys_rst` is 1 while `bdrst_en` is 1. The pin low that this pull-down causes never starts a hardware reset.
- R6: A `bdrst_set` pulse sets `bdrst_en`. Software and watchdog resets leave it set. Only a filtered hardware reset clears it.
- R7: A high-to-low transition of `nmi_pin` makes `nmi_trap` 1 for exactly one cycle, two clock edges after the change. A low-to-high transition gives no trap.
- R8: A `pwrdn_req` sets `pwrdn_active` only if the synchronized `nmi_pin` is low. Otherwise the request is dropped and `pwrdn_active` stays 0.
- R9: `pwrdn_active` stays 1 through software and watchdog resets and is cleared by a filtered hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the unit itself, active low |
| rst_pin_n | input | 1 | Reset pin level as seen at the pad, active low |
| sw_rst_req | input | 1 | One-cycle software reset request |
| wdt_timeout | input | 1 | One-cycle watchdog timeout |
| einit_cmd | input | 1 | End-of-initialization command |
| bdrst_set | input | 1 | Sets the bidirectional reset enable |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| pwrdn_req | input | 1 | Power-down request |
| sys_rst | output | 1 | Internal reset, active high |
| rst_ind_n | output | 1 | Reset indication, low until end of initialization |
| rst_pin_pd | output | 1 | Open-drain pull-down enable for the reset pin |
| bdrst_en | output | 1 | Current bidirectional reset enable |
| rst_cause | output | 2 | Last reset cause: 0 none, 1 hardware, 2 software, 3 watchdog |
| nmi_trap | output | 1 | One-cycle non-maskable trap request |
| pwrdn_active | output | 1 | Power-down entered |

## Verification
The hardest case to reach is a software or watchdog reset with the bidirectional mode on. Here the unit's own pull-down comes back into the filter through the pin, and a wrong mask would show up only as a second, unexpected hardware reset. To reach it, the bench models the pad as the external level ANDed with the inverted pull-down. It sets the enable, fires a software reset and then a watchdog reset. The scoreboard expects exactly one reset record for each, with the pull-down active for SEQ_CYC cycles. Filter acceptance is probed with pulses both at the reject length and one cycle short of the pass length.

// File: rtl/rnc_pkg.sv
package rnc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_HW   = 2'd1,
    CAUSE_SW   = 2'd2,
    CAUSE_WDT  = 2'd3
  } rst_cause_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_HOLD  = 2'd1,
    SQ_COUNT = 2'd2
  } seq_state_e;

  // saturating increment toward lim
  function automatic int unsigned sat_inc(int unsigned cnt, int unsigned lim);
    return (cnt >= lim) ? lim : cnt + 1;
  endfunction

  // true when a count reached its limit
  function automatic logic at_lim(int unsigned cnt, int unsigned lim);
    return cnt == lim;
  endfunction

endpackage

// File: rtl/rnc_spike_filter.sv
module rnc_spike_filter
  import rnc_pkg::*;
#(
  parameter int unsigned PASS_CYC   = 6,
  parameter int unsigned REJECT_CYC = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  input  logic mask,
  output logic hw_low
);

  localparam int unsigned CW = $clog2(PASS_CYC + 1);

  generate
    if (PASS_CYC <= REJECT_CYC) begin : g_bad_cfg
      initial $error("spike filter: PASS_CYC must exceed REJECT_CYC");
    end
  endgenerate

  logic          s1, s2;
  logic          m1, m2;
  logic [CW-1:0] cnt;
  logic          masked;
  logic          cnt_adv;

  // self-driven pull-down and its sync echo are hidden
  assign masked  = mask | m1 | m2;
  assign cnt_adv = !s2 && !masked;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      m1  <= 1'b0;
      m2  <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      m1 <= mask;
      m2 <= m1;
      if (cnt_adv) cnt <= CW'(sat_inc(32'(cnt), PASS_CYC));
      else         cnt <= '0;
    end
  end

  assign hw_low = at_lim(32'(cnt), PASS_CYC);

  assert_accept_low_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hw_low) |-> $past(cnt_adv));

  assert_mask_hides_R5: assert property (@(posedge clk) disable iff (!por_n)
    mask |=> !hw_low);

endmodule

// File: rtl/rnc_nmi_unit.sv
module rnc_nmi_unit (
  input  logic clk,
  input  logic por_n,
  input  logic nmi_pin,
  input  logic pwrdn_req,
  input  logic hw_clr,
  output logic nmi_trap,
  output logic pwrdn_active
);

  logic n1, n2, n3;
  logic nmi_lvl;
  logic pd_q;

  assign nmi_lvl = n2;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      n1 <= 1'b1;
      n2 <= 1'b1;
      n3 <= 1'b1;
    end else begin
      n1 <= nmi_pin;
      n2 <= n1;
      n3 <= n2;
    end
  end

  assign nmi_trap = n3 & ~n2;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      pd_q <= 1'b0;
    else if (hw_clr)                 pd_q <= 1'b0;
    else if (pwrdn_req && !nmi_lvl)  pd_q <= 1'b1;
  end

  assign pwrdn_active = pd_q;

  assert_trap_single_R7: assert property (@(posedge clk) disable iff (!por_n)
    nmi_trap |=> !nmi_trap);

  assert_pwrdn_gate_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pwrdn_active) |-> ($past(pwrdn_req) && !$past(nmi_lvl)));

  assert_pwrdn_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pwrdn_active) |-> $past(hw_clr));

endmodule

// File: rtl/rnc_rst_seq.sv
module rnc_rst_seq
  import rnc_pkg::*;
#(
  parameter int unsigned SEQ_CYC = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_low,
  input  logic       sw_req,
  input  logic       wdt_req,
  input  logic       einit,
  input  logic       bd_set,
  output logic       sys_rst,
  output logic       rst_ind_n,
  output logic       pin_pd,
  output logic [1:0] cause,
  output logic       bd_en
);

  localparam int unsigned CW = (SEQ_CYC > 1) ? $clog2(SEQ_CYC) : 1;

  seq_state_e    state;
  logic [CW-1:0] cnt;
  rst_cause_e    cause_q;
  logic          ind_low;
  logic          bd_q;
  logic          soft_start;
  logic          seq_last;

  assign soft_start = (state == SQ_IDLE) && (sw_req || wdt_req);
  assign seq_last   = at_lim(32'(cnt), SEQ_CYC - 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      cause_q <= CAUSE_NONE;
    end else if (hw_low) begin
      state   <= SQ_HOLD;
      cnt     <= '0;
      cause_q <= CAUSE_HW;
    end else begin
      unique case (state)
        SQ_HOLD: begin
          state <= SQ_COUNT;
          cnt   <= '0;
        end
        SQ_COUNT: begin
          if (seq_last) state <= SQ_IDLE;
          else          cnt   <= cnt + 1'b1;
        end
        default: begin
          if (soft_start) begin
            state   <= SQ_COUNT;
            cnt     <= '0;
            cause_q <= wdt_req ? CAUSE_WDT : CAUSE_SW;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            ind_low <= 1'b1;
    else if (hw_low || soft_start)         ind_low <= 1'b1;
    else if (state == SQ_IDLE && einit)    ind_low <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      bd_q <= 1'b0;
    else if (hw_low) bd_q <= 1'b0;
    else if (bd_set) bd_q <= 1'b1;
  end

  assign sys_rst   = (state != SQ_IDLE);
  assign rst_ind_n = ~ind_low;
  assign pin_pd    = bd_q & sys_rst;
  assign cause     = cause_q;
  assign bd_en     = bd_q;

  assert_ind_in_rst_R4: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> !rst_ind_n);

  assert_ind_release_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_ind_n) |-> ($past(einit) && !$past(sys_rst)));

  assert_pd_in_rst_R5: assert property (@(posedge clk) disable iff (!por_n)
    pin_pd |-> sys_rst);

  assert_bd_clear_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(bd_en) |-> $past(hw_low));

  assert_hw_wins_R3: assert property (@(posedge clk) disable iff (!por_n)
    hw_low |=> (sys_rst && cause == CAUSE_HW));

endmodule

// File: rtl/rst_nmi_ctrl.sv
module rst_nmi_ctrl #(
  parameter int unsigned PASS_CYC   = 6,
  parameter int unsigned REJECT_CYC = 3,
  parameter int unsigned SEQ_CYC    = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin_n,
  input  logic       sw_rst_req,
  input  logic       wdt_timeout,
  input  logic       einit_cmd,
  input  logic       bdrst_set,
  input  logic       nmi_pin,
  input  logic       pwrdn_req,
  output logic       sys_rst,
  output logic       rst_ind_n,
  output logic       rst_pin_pd,
  output logic       bdrst_en,
  output logic [1:0] rst_cause,
  output logic       nmi_trap,
  output logic       pwrdn_active
);

  logic hw_low;
  logic pd_int;

  rnc_spike_filter #(.PASS_CYC(PASS_CYC), .REJECT_CYC(REJECT_CYC)) u_filt (
    .clk    (clk),
    .por_n  (por_n),
    .pin_n  (rst_pin_n),
    .mask   (pd_int),
    .hw_low (hw_low)
  );

  rnc_rst_seq #(.SEQ_CYC(SEQ_CYC)) u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .hw_low    (hw_low),
    .sw_req    (sw_rst_req),
    .wdt_req   (wdt_timeout),
    .einit     (einit_cmd),
    .bd_set    (bdrst_set),
    .sys_rst   (sys_rst),
    .rst_ind_n (rst_ind_n),
    .pin_pd    (pd_int),
    .cause     (rst_cause),
    .bd_en     (bdrst_en)
  );

  rnc_nmi_unit u_nmi (
    .clk          (clk),
    .por_n        (por_n),
    .nmi_pin      (nmi_pin),
    .pwrdn_req    (pwrdn_req),
    .hw_clr       (hw_low),
    .nmi_trap     (nmi_trap),
    .pwrdn_active (pwrdn_active)
  );

  assign rst_pin_pd = pd_int;

endmodule

// File: tb/rst_nmi_ctrl_tb.sv
module rst_nmi_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PASS  = 6;
  localparam int REJ   = 3;
  localparam int SEQ   = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ext_pin_n = 1'b1;
  logic sw_rst_req = 1'b0, wdt_timeout = 1'b0, einit_cmd = 1'b0;
  logic bdrst_set = 1'b0, nmi_pin = 1'b1, pwrdn_req = 1'b0;
  logic sys_rst, rst_ind_n, rst_pin_pd, bdrst_en, nmi_trap, pwrdn_active;
  logic [1:0] rst_cause;
  logic rst_pin_n;

  // pad model: open-drain pull-down wins over the external level
  assign rst_pin_n = ext_pin_n & ~rst_pin_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_nmi_ctrl #(.PASS_CYC(PASS), .REJECT_CYC(REJ), .SEQ_CYC(SEQ)) u_dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .sw_rst_req(sw_rst_req),
    .wdt_timeout(wdt_timeout), .einit_cmd(einit_cmd), .bdrst_set(bdrst_set),
    .nmi_pin(nmi_pin), .pwrdn_req(pwrdn_req), .sys_rst(sys_rst),
    .rst_ind_n(rst_ind_n), .rst_pin_pd(rst_pin_pd), .bdrst_en(bdrst_en),
    .rst_cause(rst_cause), .nmi_trap(nmi_trap), .pwrdn_active(pwrdn_active)
  );

  typedef struct {
    int    cause;
    int    len;   // -1: not checked
    int    pd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  int   starts = 0;
  int   traps = 0;
  int   cycles = 0;

  task automatic check(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rst(int cause, int len, int pd, string tag);
    exp_t e;
    e.cause = cause; e.len = len; e.pd = pd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse_sw();  sw_rst_req = 1; cyc(1); sw_rst_req = 0; endtask
  task automatic pulse_wdt(); wdt_timeout = 1; cyc(1); wdt_timeout = 0; endtask
  task automatic pulse_einit(); einit_cmd = 1; cyc(1); einit_cmd = 0; endtask
  task automatic pin_low(int n); ext_pin_n = 0; cyc(n); ext_pin_n = 1; endtask

  // monitor: rebuilds each reset episode and compares with the queue
  logic prev_rst = 0, prev_trap = 0;
  int   len = 0, pdc = 0;
  always @(negedge clk) begin
    if (por_n) begin
      cycles++;
      if (sys_rst && !prev_rst) starts++;
      if (sys_rst) begin
        len++;
        if (rst_pin_pd) pdc++;
      end
      if (!sys_rst && prev_rst) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected reset episode", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " cause"}, int'(rst_cause), e.cause);
          if (e.len >= 0) check({e.tag, " length"}, len, e.len);
          check({e.tag, " pull-down cycles"}, pdc, e.pd);
        end
        len = 0;
        pdc = 0;
      end
      if (nmi_trap) traps++;
      if (nmi_trap && prev_trap) check("R7 trap wider than one cycle", 1, 0);
      prev_rst  = sys_rst;
      prev_trap = nmi_trap;
    end
  end

  always @(negedge clk) begin
    if (cycles > 50000) begin
      check("watchdog expired", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0, t0;
    cyc(3);
    por_n = 1;
    cyc(2);
    // reset state (R4)
    check("R4 ind low after power-on", rst_ind_n, 0);
    check("R2 no internal reset idle", sys_rst, 0);
    check("R3 cause none", rst_cause, 0);
    check("R5 no pull-down", rst_pin_pd, 0);
    check("R8 pwrdn clear", pwrdn_active, 0);
    pulse_einit();
    check("R4 ind released by einit", rst_ind_n, 1);

    // software reset with early einit (R3, R4)
    expect_rst(2, SEQ, 0, "R3 sw reset");
    pulse_sw();
    cyc(3);
    pulse_einit();
    cyc(SEQ + 4);
    check("R4 einit during reset ignored", rst_ind_n, 0);
    pulse_einit();
    check("R4 ind released after reset", rst_ind_n, 1);

    // watchdog reset, then simultaneous requests (R3)
    expect_rst(3, SEQ, 0, "R3 wdt reset");
    pulse_wdt();
    cyc(SEQ + 4);
    expect_rst(3, SEQ, 0, "R3 wdt beats sw");
    sw_rst_req = 1; wdt_timeout = 1; cyc(1); sw_rst_req = 0; wdt_timeout = 0;
    cyc(SEQ + 4);
    pulse_einit();

    // spike filter rejection (R1)
    s0 = starts;
    pin_low(REJ);  cyc(12);
    pin_low(PASS - 1); cyc(12);
    check("R1 short pulses ignored", starts - s0, 0);
    check("R1 ind untouched", rst_ind_n, 1);

    // accepted hardware reset (R2)
    expect_rst(1, -1, 0, "R2 hw reset");
    pin_low(PASS + 5);
    cyc(PASS + SEQ + 10);
    check("R2 exactly one hw episode", starts - s0, 1);
    pulse_einit();

    // bidirectional mode with soft sources (R5, R6)
    bdrst_set = 1; cyc(1); bdrst_set = 0;
    check("R6 enable set", bdrst_en, 1);
    expect_rst(2, SEQ, SEQ, "R5 sw reset drives pin");
    pulse_sw();
    cyc(SEQ + 12);
    expect_rst(3, SEQ, SEQ, "R5 wdt reset drives pin");
    pulse_wdt();
    cyc(SEQ + 12);
    check("R6 enable kept over soft resets", bdrst_en, 1);
    expect_rst(1, -1, 0, "R6 hw reset");
    pin_low(PASS + 2);
    cyc(PASS + SEQ + 10);
    check("R6 enable cleared by hw reset", bdrst_en, 0);
    expect_rst(2, SEQ, 0, "R5 no drive after clear");
    pulse_sw();
    cyc(SEQ + 6);
    pulse_einit();

    // NMI edges (R7)
    t0 = traps;
    nmi_pin = 0;
    cyc(2);
    check("R7 trap two edges after fall", nmi_trap, 1);
    cyc(1);
    check("R7 trap drops next cycle", nmi_trap, 0);
    cyc(4);
    nmi_pin = 1;
    cyc(6);
    check("R7 one trap per falling edge only", traps - t0, 1);

    // power-down qualification (R8, R9)
    pwrdn_req = 1; cyc(1); pwrdn_req = 0;
    cyc(1);
    check("R8 pwrdn dropped with nmi high", pwrdn_active, 0);
    nmi_pin = 0;
    cyc(5);
    pwrdn_req = 1; cyc(1); pwrdn_req = 0;
    check("R8 pwrdn entered with nmi low", pwrdn_active, 1);
    expect_rst(2, SEQ, 0, "R9 sw reset in pwrdn");
    pulse_sw();
    cyc(SEQ + 4);
    check("R9 pwrdn kept over sw reset", pwrdn_active, 1);
    expect_rst(1, -1, 0, "R9 hw reset");
    pin_low(PASS + 3);
    cyc(PASS + SEQ + 10);
    check("R9 pwrdn cleared by hw reset", pwrdn_active, 0);
    nmi_pin = 1;
    cyc(4);

    check("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule